// File: doc/BRIEF.md
# Bitmap Overlay Stage for a Chunked Pixel Stream

This stage sits in a chain of object stages that the pixel stream flows through. Each cycle the stream may carry one chunk. A chunk is `CHUNK_W` one-bit pixels of a single raster row. Each chunk comes with its row number and its chunk column. The stage holds a one-bit bitmap at a fixed rectangle of the image, given by the parameters `BOX_LEFT`, `BOX_RIGHT` (exclusive pixel column), `BOX_TOP` and `BOX_BOTTOM` (exclusive row). Where a bitmap pixel is set, the stage paints the foreground value over the passing pixel. Everywhere else the passing pixel is left untouched.

A pair of start/stop comparators decides whether the current chunk falls inside the rectangle. The bitmap storage holds only the chunks the rectangle covers, which is ((BOX_RIGHT-1)/CHUNK_W - BOX_LEFT/CHUNK_W + 1) chunk columns times (BOX_BOTTOM - BOX_TOP) rows, stored in raster order. It is built from banks of eight chunk words. No coordinate arithmetic forms the read address. Instead, a counter advances on each in-box chunk and supplies the address. At the left and right chunks of the rectangle, the pixels that lie outside it are masked off.

The memory is loaded through a simple write port. A write is taken only in a cycle with no valid chunk on the stream. `CHUNK_W` must be a multiple of 8. The stream and the bitmap both carry one bit per pixel.

Top module: `bmpOverlay`

## Requirements
- R1: While `rstN` is low, `outValid` and `outPix` are cleared to 0 at each clock edge.
- R2: `outValid` equals the `inValid` of the previous cycle, and `outPix` carries the result for the chunk presented in that previous cycle.
- R3: A valid chunk whose row lies outside [BOX_TOP, BOX_BOTTOM), or whose pixels all lie outside [BOX_LEFT, BOX_RIGHT), leaves the stage unchanged.
- R4: In a valid in-box chunk, bit p of `outPix` is the foreground bit `FG_BIT` wherever bit p of the addressed bitmap word is 1 and the pixel is inside the rectangle; otherwise it is bit p of `inPix`. Bit p is the pixel at image column inCol*CHUNK_W + p, so bit 0 is the leftmost pixel.
- R5: In the leftmost in-box chunk column, bits p with inCol*CHUNK_W + p < BOX_LEFT pass through unchanged, whatever the bitmap word holds.
- R6: In the rightmost in-box chunk column, bits p with inCol*CHUNK_W + p >= BOX_RIGHT pass through unchanged, whatever the bitmap word holds.
- R7: The k-th valid in-box chunk of a frame (counting from 0) is painted from bitmap word k. The word address never exceeds the stored chunk count.
- R8: A valid chunk with `inFrameStart` high restarts word addressing at 0, even when the previous frame stopped part-way.
- R9: Cycles with `inValid` low do not move the word address.
- R10: A host write with `hostWrEn` high is stored at word `hostAddr` only when `inValid` is low in the same cycle. When `inValid` is high, the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | A chunk is present on the input |
| inFrameStart | input | 1 | Marks the first chunk of a frame |
| inRow | input | ROW_W | Raster row of the chunk |
| inCol | input | COL_W | Chunk column of the chunk |
| inPix | input | CHUNK_W | Incoming pixels, bit 0 leftmost |
| hostWrEn | input | 1 | Bitmap word write request |
| hostAddr | input | ADDR_W | Bitmap word index, raster order |
| hostData | input | CHUNK_W | Bitmap word, bit 0 leftmost |
| outValid | output | 1 | A chunk is present on the output |
| outPix | output | CHUNK_W | Outgoing pixels |

## Verification
The bench builds the stage with 16-pixel chunks on a 64-pixel by 10-row image. The rectangle spans pixels 5 to 42 and rows 3 to 6. That gives twelve stored words in two banks, with a partial chunk at each side. With these values every chunk position of every frame can be swept: chunks outside the rectangle, both masked edge columns, the full middle column, and the step from one bank to the next. Further frames add idle gaps between chunks, restart the frame part-way through, use an all-ones bitmap to expose the edge masks, and try a write while the stream is busy.

// File: rtl/bmpOverlayPkg.sv
package bmpOverlayPkg;

  // strobes passed from control to datapath
  typedef struct packed {
    logic memWr;      // commit host word to storage
    logic boxHit;     // current valid chunk overlaps the box
    logic leftEdge;   // current chunk is the box's first chunk column
    logic rightEdge;  // current chunk is the box's last chunk column
  } bmpStrobe_t;

  localparam int WORDS_PER_BANK = 8;
  localparam int BANK_OFS_W     = 3;

endpackage

// File: rtl/bmpBoxDecode.sv
module bmpBoxDecode #(
  parameter int ROW_W      = 4,
  parameter int COL_W      = 3,
  parameter int ROW_START  = 3,
  parameter int ROW_STOP   = 7,
  parameter int COL_FIRST  = 0,
  parameter int COL_LAST   = 2
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  output logic             hit,
  output logic             firstCol,
  output logic             lastCol
);

  logic rowInside;
  logic colInside;

  // start/stop comparators, evaluated as signed ints
  always_comb begin
    rowInside = (int'(row) >= ROW_START) && (int'(row) < ROW_STOP);
    colInside = (int'(col) >= COL_FIRST) && (int'(col) <= COL_LAST);
    hit       = rowInside && colInside;
    firstCol  = (int'(col) == COL_FIRST);
    lastCol   = (int'(col) == COL_LAST);
  end

endmodule

// File: rtl/bmpOverlayCtrl.sv
module bmpOverlayCtrl
  import bmpOverlayPkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int NUM_CHUNKS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inFrameStart,
  input  logic              boxHit,
  input  logic              firstCol,
  input  logic              lastCol,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  output bmpStrobe_t        strobe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] chunkCnt
);

  logic addrInRange;
  logic hitNow;

  assign addrInRange = int'(hostAddr) < NUM_CHUNKS;
  assign hitNow      = inValid && boxHit;

  // a frame-start chunk reads word 0 regardless of leftover count
  assign rdAddr = inFrameStart ? '0 : chunkCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chunkCnt <= '0;
    end else if (inValid) begin
      if (boxHit)
        chunkCnt <= rdAddr + ADDR_W'(1);
      else if (inFrameStart)
        chunkCnt <= '0;
    end
  end

  always_comb begin
    strobe.memWr     = hostWrEn && !inValid && addrInRange;
    strobe.boxHit    = hitNow;
    strobe.leftEdge  = hitNow && firstCol;
    strobe.rightEdge = hitNow && lastCol;
  end

endmodule

// File: rtl/bmpOverlayDatapath.sv
module bmpOverlayDatapath
  import bmpOverlayPkg::*;
#(
  parameter int CHUNK_W   = 16,
  parameter int ADDR_W    = 4,
  parameter int NUM_BANKS = 2,
  parameter int LEFT_OFS  = 5,
  parameter int RIGHT_OFS = 10,
  parameter bit FG_BIT    = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  bmpStrobe_t         strobe,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [CHUNK_W-1:0] wrData,
  input  logic               inValid,
  input  logic [CHUNK_W-1:0] inPix,
  output logic               outValid,
  output logic [CHUNK_W-1:0] outPix
);

  localparam int SEL_W = ADDR_W - BANK_OFS_W;

  logic [CHUNK_W-1:0] bankRd [NUM_BANKS];
  logic [CHUNK_W-1:0] word;
  logic [CHUNK_W-1:0] edgeMask;
  logic [CHUNK_W-1:0] merged;
  logic [SEL_W-1:0]   rdSel;
  logic [SEL_W-1:0]   wrSel;

  assign rdSel = rdAddr[ADDR_W-1:BANK_OFS_W];
  assign wrSel = wrAddr[ADDR_W-1:BANK_OFS_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CHUNK_W-1:0] mem [WORDS_PER_BANK];
    always_ff @(posedge clk) begin
      if (strobe.memWr && wrSel == SEL_W'(b))
        mem[wrAddr[BANK_OFS_W-1:0]] <= wrData;
    end
    assign bankRd[b] = mem[rdAddr[BANK_OFS_W-1:0]];
  end

  always_comb begin
    word = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (rdSel == SEL_W'(b)) word = bankRd[b];
  end

  // per-pixel box mask: trims the partial chunks at both box sides
  for (genvar p = 0; p < CHUNK_W; p++) begin : g_pix
    localparam bit LEFT_OK  = (p >= LEFT_OFS);
    localparam bit RIGHT_OK = (p <= RIGHT_OFS);
    assign edgeMask[p] = strobe.boxHit
                       && (!strobe.leftEdge  || LEFT_OK)
                       && (!strobe.rightEdge || RIGHT_OK);
    assign merged[p]   = (edgeMask[p] && word[p]) ? FG_BIT : inPix[p];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= inValid;
      outPix   <= inValid ? merged : '0;
    end
  end

endmodule

// File: rtl/bmpOverlay.sv
module bmpOverlay
  import bmpOverlayPkg::*;
#(
  parameter int CHUNK_W    = 16,
  parameter int ROW_W      = 4,
  parameter int COL_W      = 3,
  parameter int BOX_LEFT   = 5,
  parameter int BOX_RIGHT  = 43,
  parameter int BOX_TOP    = 3,
  parameter int BOX_BOTTOM = 7,
  parameter bit FG_BIT     = 1'b1,
  parameter int NUM_CHUNKS = (((BOX_RIGHT - 1) / CHUNK_W) - (BOX_LEFT / CHUNK_W) + 1)
                             * (BOX_BOTTOM - BOX_TOP),
  parameter int ADDR_W     = ($clog2(NUM_CHUNKS + 1) > 4) ? $clog2(NUM_CHUNKS + 1) : 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               inFrameStart,
  input  logic [ROW_W-1:0]   inRow,
  input  logic [COL_W-1:0]   inCol,
  input  logic [CHUNK_W-1:0] inPix,
  input  logic               hostWrEn,
  input  logic [ADDR_W-1:0]  hostAddr,
  input  logic [CHUNK_W-1:0] hostData,
  output logic               outValid,
  output logic [CHUNK_W-1:0] outPix
);

  localparam int COL_FIRST = BOX_LEFT / CHUNK_W;
  localparam int COL_LAST  = (BOX_RIGHT - 1) / CHUNK_W;
  localparam int LEFT_OFS  = BOX_LEFT % CHUNK_W;
  localparam int RIGHT_OFS = (BOX_RIGHT - 1) % CHUNK_W;
  localparam int NUM_BANKS = (NUM_CHUNKS + WORDS_PER_BANK - 1) / WORDS_PER_BANK;

  logic              boxHit;
  logic              firstCol;
  logic              lastCol;
  bmpStrobe_t        strobe;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] chunkCnt;

  bmpBoxDecode #(
    .ROW_W(ROW_W), .COL_W(COL_W),
    .ROW_START(BOX_TOP), .ROW_STOP(BOX_BOTTOM),
    .COL_FIRST(COL_FIRST), .COL_LAST(COL_LAST)
  ) u_box (
    .row(inRow), .col(inCol),
    .hit(boxHit), .firstCol(firstCol), .lastCol(lastCol)
  );

  bmpOverlayCtrl #(
    .ADDR_W(ADDR_W), .NUM_CHUNKS(NUM_CHUNKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inFrameStart(inFrameStart),
    .boxHit(boxHit), .firstCol(firstCol), .lastCol(lastCol),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .strobe(strobe), .rdAddr(rdAddr), .chunkCnt(chunkCnt)
  );

  bmpOverlayDatapath #(
    .CHUNK_W(CHUNK_W), .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS),
    .LEFT_OFS(LEFT_OFS), .RIGHT_OFS(RIGHT_OFS), .FG_BIT(FG_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .rdAddr(rdAddr),
    .wrAddr(hostAddr), .wrData(hostData),
    .inValid(inValid), .inPix(inPix),
    .outValid(outValid), .outPix(outPix)
  );

endmodule

// File: rtl/bmpOverlay_chk.sv
module bmpOverlay_chk #(
  parameter int CHUNK_W    = 16,
  parameter int ROW_W      = 4,
  parameter int COL_W      = 3,
  parameter int BOX_LEFT   = 5,
  parameter int BOX_RIGHT  = 43,
  parameter int BOX_TOP    = 3,
  parameter int BOX_BOTTOM = 7,
  parameter int NUM_CHUNKS = 12,
  parameter int ADDR_W     = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               inFrameStart,
  input logic [ROW_W-1:0]   inRow,
  input logic [COL_W-1:0]   inCol,
  input logic [CHUNK_W-1:0] inPix,
  input logic               outValid,
  input logic [CHUNK_W-1:0] outPix,
  input logic [ADDR_W-1:0]  chunkCnt
);

  // overlap test in pixel space, independent of the chunk-column decode
  logic overlap;
  always_comb begin
    overlap = (int'(inRow) >= BOX_TOP) && (int'(inRow) < BOX_BOTTOM)
           && (int'(inCol) * CHUNK_W < BOX_RIGHT)
           && (int'(inCol) * CHUNK_W + CHUNK_W > BOX_LEFT);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!outValid && outPix == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R3
  outside_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !overlap) |=> (outPix == $past(inPix)));

  // R8
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inFrameStart && !overlap) |=> (chunkCnt == '0));

  // R9
  bubble_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(chunkCnt));

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(chunkCnt) <= NUM_CHUNKS);

endmodule

bind bmpOverlay bmpOverlay_chk #(
  .CHUNK_W(CHUNK_W), .ROW_W(ROW_W), .COL_W(COL_W),
  .BOX_LEFT(BOX_LEFT), .BOX_RIGHT(BOX_RIGHT),
  .BOX_TOP(BOX_TOP), .BOX_BOTTOM(BOX_BOTTOM),
  .NUM_CHUNKS(NUM_CHUNKS), .ADDR_W(ADDR_W)
) chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inFrameStart(inFrameStart),
  .inRow(inRow), .inCol(inCol), .inPix(inPix),
  .outValid(outValid), .outPix(outPix), .chunkCnt(chunkCnt)
);

// File: tb/bmpOverlay_test.sv
module bmpOverlay_test;

  localparam int CLK_PERIOD = 10;
  localparam int W      = 16;
  localparam int ROWS   = 10;
  localparam int COLS   = 4;
  localparam int LEFT   = 5;
  localparam int RIGHT  = 43;
  localparam int TOP    = 3;
  localparam int BOTTOM = 7;
  localparam int CFIRST = LEFT / W;
  localparam int CLAST  = (RIGHT - 1) / W;
  localparam int NCH    = (CLAST - CFIRST + 1) * (BOTTOM - TOP);
  localparam int AW     = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic          inFrameStart = 1'b0;
  logic [3:0]    inRow = '0;
  logic [2:0]    inCol = '0;
  logic [W-1:0]  inPix = '0;
  logic          hostWrEn = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [W-1:0]  hostData = '0;
  logic          outValid;
  logic [W-1:0]  outPix;

  int nChecks = 0;
  int nBad = 0;
  logic [W-1:0] model [NCH];
  int kModel = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bmpOverlay #(
    .CHUNK_W(W), .ROW_W(4), .COL_W(3),
    .BOX_LEFT(LEFT), .BOX_RIGHT(RIGHT), .BOX_TOP(TOP), .BOX_BOTTOM(BOTTOM),
    .FG_BIT(1'b1)
  ) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFrameStart(inFrameStart),
    .inRow(inRow), .inCol(inCol), .inPix(inPix),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostData(hostData),
    .outValid(outValid), .outPix(outPix)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] bmpWord(int k, int seed);
    return W'(16'hA5C3 ^ (k * 16'h1F07) ^ (seed * 16'h3535));
  endfunction

  function automatic logic [W-1:0] pixPat(int row, int col, int f);
    return W'(((row * 16'h03B1) + (col * 16'h006D) + (f * 16'h0111)) ^ 16'h0F0F);
  endfunction

  // one stream cycle; expected value computed from the requirements
  task automatic drive(bit v, bit fs, int row, int col, logic [W-1:0] pix, string ftag);
    logic [W-1:0] exp;
    bit inBox;
    string tag;
    @(negedge clk);
    inValid = v; inFrameStart = fs;
    inRow = 4'(row); inCol = 3'(col); inPix = pix;
    if (v && fs) kModel = 0;
    inBox = (row >= TOP) && (row < BOTTOM) && (col >= CFIRST) && (col <= CLAST);
    exp = pix;
    if (v && inBox) begin
      for (int p = 0; p < W; p++) begin
        int gx;
        gx = col * W + p;
        if (gx >= LEFT && gx < RIGHT && model[kModel][p]) exp[p] = 1'b1;
      end
    end
    if (!inBox)           tag = "R3";
    else if (col == CFIRST) tag = "R5/R7";
    else if (col == CLAST)  tag = "R6/R7";
    else                    tag = "R4/R7";
    @(posedge clk); #1;
    check({"R2 valid ", ftag}, W'(outValid), W'(v));
    if (v) check({tag, " ", ftag}, outPix, exp);
    if (v && inBox) kModel++;
  endtask

  task automatic hostWrite(int addr, logic [W-1:0] data, bit busy);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = AW'(addr); hostData = data;
    inValid = busy; inFrameStart = 1'b0; inRow = '0; inCol = '0; inPix = 16'h1234;
    @(posedge clk); #1;
    hostWrEn = 1'b0;
    if (!busy) model[addr] = data;
    else check("R10 busy write pass", outPix, 16'h1234);
  endtask

  task automatic runFrame(int f, bit bubbles, int lastRow, string ftag);
    for (int row = 0; row < ROWS && row <= lastRow; row++)
      for (int col = 0; col < COLS; col++) begin
        drive(1'b1, row == 0 && col == 0, row, col, pixPat(row, col, f), ftag);
        if (bubbles && ((row + col) % 3 == 0))
          drive(1'b0, 1'b0, row, col, 16'hFFFF, {ftag, " R9 gap"});
      end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nBad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", W'(outValid), '0);
    check("R1 reset pix", outPix, '0);
    @(negedge clk);
    rstN = 1'b1;

    for (int k = 0; k < NCH; k++) hostWrite(k, bmpWord(k, 0), 1'b0);
    runFrame(0, 1'b0, ROWS, "plain");
    runFrame(1, 1'b1, ROWS, "bubbles");
    runFrame(2, 1'b0, 4, "partial");
    runFrame(3, 1'b0, ROWS, "R8 restart");

    for (int k = 0; k < NCH; k++) hostWrite(k, '1, 1'b0);
    runFrame(4, 1'b0, ROWS, "ones");
    for (int k = 0; k < NCH; k++) hostWrite(k, '1, 1'b0);
    for (int f = 5; f < 7; f++) begin
      for (int k = 0; k < NCH; k++) hostWrite(k, bmpWord(k, f), 1'b0);
      runFrame(f, 1'b0, ROWS, "sweep");
    end

    hostWrite(0, 16'h0000, 1'b1);
    hostWrite(NCH - 1, 16'h0000, 1'b1);
    runFrame(7, 1'b0, ROWS, "R10 after busy writes");

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule